// File: doc/BRIEF.md
# Iterative Integer Divide Unit

This block is the divide engine of a 64-bit execution pipeline. Issue logic hands it one operation as a single-cycle valid pulse. The pulse carries two unsigned magnitudes and a handful of control flags. The flags choose word or doubleword width, an extended mode in which the dividend is shifted up, quotient or remainder output, negation of the final value, and whether a condition field is written. The caller resolves operand signs beforehand. The unit works only on magnitudes and applies one optional negation at the end.

The core is a restoring shift-subtract loop that retires one quotient bit per clock. Word operations start the loop with the dividend already aligned to the upper half, so they need half as many steps. A three-state controller runs the loop. ST_IDLE waits for an issue pulse and loads the operands (IDLE->STEP on an accepted issue). ST_STEP runs one subtract step per cycle until the step counter reaches zero (STEP->STEP while the counter is non-zero, STEP->WRAP at zero). ST_WRAP selects and negates the result, forms the condition code and registers every output (WRAP->IDLE, always). The result appears as a one-cycle completion pulse. The pulse carries the echoed destination register number, the value and, on request, a 4-bit compare-with-zero code in the top field of a 32-bit condition word.

Top module: `int_div_unit`

## Requirements
- R1: An issue pulse is accepted only while the unit is idle. A pulse that arrives while an operation is in flight has no effect: the in-flight result and destination are unchanged, and no second completion follows.
- R2: `done_valid` is low in the cycle after an accepted issue, and it is a single-cycle pulse. After reset `done_valid`, `done_reg_we` and `done_cc_we` are low.
- R3: A doubleword operation completes with `done_valid` high 65 clock edges after the edge that accepted it. A word operation (either mode) completes after 33 edges.
- R4: On completion `done_reg_we` is 1 and `done_reg_num` equals the destination number given at issue.
- R5: In plain doubleword mode `done_data` is the unsigned quotient floor(dividend/divisor). For example, 0x10001000 / 0x1111 gives 0xF001.
- R6: When `issue_negate` is 1 the result is the two's-complement negation of the unsigned quotient or remainder.
- R7: With `issue_rem` = 1 the remainder replaces the quotient. If the caller sets `issue_negate` to the dividend's sign, the result is the truncating signed remainder.
- R8: In extended doubleword mode the dividend is the 128-bit value {dividend, 64 zero bits}, and the low 64 bits of the quotient are returned. This holds whenever divisor > dividend.
- R9: In word mode only the low 32 bits of divisor and dividend are used, and the low 32 bits of `done_data` carry the result.
- R10: In extended word mode the 32-bit operand is taken from dividend bits 63..32. The low 32 bits of floor(operand·2^32 / divisor[31:0]) are returned whenever divisor[31:0] > operand.
- R11: With `issue_set_cc` = 0, `done_cc_we`, `done_cc_mask` and `done_cc_word` are all zero. With 1, `done_cc_we` = 1 and `done_cc_mask` = 0x80. `done_cc_word` bit 31 = less than zero, bit 30 = greater than zero, bit 29 = equal to zero, bit 28 = 0, and bits 27..0 are zero.
- R12: The code compares the full 64-bit result as a signed value in doubleword mode, and the low 32 bits as a signed value in word mode.
- R13: A zero divisor still completes within the R3 timing, with bit 28 of the condition word equal to 0. The result value is unspecified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issue_valid | input | 1 | Single-cycle operation request |
| issue_dest | input | 5 | Destination register number |
| issue_dividend | input | 64 | Dividend magnitude |
| issue_divisor | input | 64 | Divisor magnitude |
| issue_negate | input | 1 | Negate the final result |
| issue_word | input | 1 | 32-bit operation |
| issue_ext | input | 1 | Extended (shifted dividend) mode |
| issue_rem | input | 1 | Return remainder instead of quotient |
| issue_set_cc | input | 1 | Write the condition field |
| done_valid | output | 1 | Completion pulse |
| done_reg_we | output | 1 | Register write enable |
| done_reg_num | output | 5 | Echoed destination number |
| done_data | output | 64 | Result value |
| done_cc_we | output | 1 | Condition write enable |
| done_cc_mask | output | 8 | Condition field mask |
| done_cc_word | output | 32 | Condition word, code in bits 31..28 |

## Verification
The hardest case to reach from the ports is a second issue pulse that lands while a division is still stepping. Well-behaved issue logic never produces it, yet nothing else shows that the operand and destination registers stay frozen. The stimulus issues a doubleword divide, waits ten cycles and pulses a new request with different operands and destination. It then checks that the single completion carries the first operation's values at the first operation's latency, and that no further completion follows. The word-mode condition code is a close second. It needs a result whose bit 31 is set while bit 63 is clear, which an unsigned word divide by one produces.

// File: rtl/div_pkg.sv
`timescale 1ns/1ps
package div_pkg;

    localparam int REG_IDX_W = 5;
    localparam int CC_MASK_W = 8;
    localparam int CC_WORD_W = 32;
    localparam int CC_CODE_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STEP,
        ST_WRAP
    } div_state_e;

    typedef struct packed {
        logic [REG_IDX_W-1:0] dest;
        logic                 negate;
        logic                 word;
        logic                 want_rem;
        logic                 set_cc;
    } div_ctx_t;

endpackage

// File: rtl/div_prep.sv
`timescale 1ns/1ps
module div_prep #(
    parameter int XLEN  = 64,
    parameter int CNT_W = $clog2(XLEN)
) (
    input  logic [XLEN-1:0]  dividend,
    input  logic [XLEN-1:0]  divisor,
    input  logic             word,
    input  logic             ext,
    output logic [XLEN-1:0]  rem_init,
    output logic [XLEN-1:0]  quo_init,
    output logic [XLEN-1:0]  dsr_init,
    output logic [CNT_W-1:0] last_idx
);
    localparam int HALF = XLEN / 2;

    // Four starting points for the shift-subtract loop. Word variants
    // pre-align the dividend so that only HALF steps are needed.
    always_comb begin
        if (word) begin
            dsr_init = {{HALF{1'b0}}, divisor[HALF-1:0]};
            last_idx = CNT_W'(HALF - 1);
            if (ext) begin
                rem_init = {{HALF{1'b0}}, dividend[XLEN-1:HALF]};
                quo_init = '0;
            end else begin
                rem_init = '0;
                quo_init = {dividend[HALF-1:0], {HALF{1'b0}}};
            end
        end else begin
            dsr_init = divisor;
            last_idx = CNT_W'(XLEN - 1);
            if (ext) begin
                rem_init = dividend;
                quo_init = '0;
            end else begin
                rem_init = '0;
                quo_init = dividend;
            end
        end
    end

endmodule

// File: rtl/div_core.sv
`timescale 1ns/1ps
module div_core #(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic            step,
    input  logic [XLEN-1:0] rem_init,
    input  logic [XLEN-1:0] quo_init,
    input  logic [XLEN-1:0] dsr_init,
    output logic [XLEN-1:0] rem_o,
    output logic [XLEN-1:0] quo_o
);
    logic [XLEN-1:0] rem_q, quo_q, dsr_q;
    logic [XLEN:0]   wide;
    logic [XLEN+1:0] diff;
    logic            take;
    logic [XLEN-1:0] rem_d;

    // One restoring step: shift in the next dividend bit, try to subtract.
    always_comb begin
        wide  = {rem_q, quo_q[XLEN-1]};
        diff  = {1'b0, wide} - {2'b00, dsr_q};
        take  = ~diff[XLEN+1];
        rem_d = take ? diff[XLEN-1:0] : wide[XLEN-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            quo_q <= '0;
            dsr_q <= '0;
        end else if (load) begin
            rem_q <= rem_init;
            quo_q <= quo_init;
            dsr_q <= dsr_init;
        end else if (step) begin
            rem_q <= rem_d;
            quo_q <= {quo_q[XLEN-2:0], take};
        end
    end

    assign rem_o = rem_q;
    assign quo_o = quo_q;

endmodule

// File: rtl/div_post.sv
`timescale 1ns/1ps
module div_post #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] quo,
    input  logic [XLEN-1:0] rem,
    input  logic            negate,
    input  logic            word,
    input  logic            want_rem,
    output logic [XLEN-1:0] result,
    output logic [3:0]      cc_code
);
    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] picked;
    logic            is_neg, is_zero;

    always_comb begin
        picked = want_rem ? rem : quo;
        result = negate ? (~picked + 1'b1) : picked;
        if (word) begin
            is_neg  = result[HALF-1];
            is_zero = (result[HALF-1:0] == '0);
        end else begin
            is_neg  = result[XLEN-1];
            is_zero = (result == '0);
        end
        cc_code = {is_neg, ~is_neg & ~is_zero, is_zero, 1'b0};
    end

endmodule

// File: rtl/int_div_unit.sv
`timescale 1ns/1ps
module int_div_unit
    import div_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 issue_valid,
    input  logic [REG_IDX_W-1:0] issue_dest,
    input  logic [XLEN-1:0]      issue_dividend,
    input  logic [XLEN-1:0]      issue_divisor,
    input  logic                 issue_negate,
    input  logic                 issue_word,
    input  logic                 issue_ext,
    input  logic                 issue_rem,
    input  logic                 issue_set_cc,
    output logic                 done_valid,
    output logic                 done_reg_we,
    output logic [REG_IDX_W-1:0] done_reg_num,
    output logic [XLEN-1:0]      done_data,
    output logic                 done_cc_we,
    output logic [CC_MASK_W-1:0] done_cc_mask,
    output logic [CC_WORD_W-1:0] done_cc_word
);
    localparam int CNT_W = $clog2(XLEN);
    localparam logic [CC_MASK_W-1:0] TOP_FIELD = {1'b1, {(CC_MASK_W-1){1'b0}}};

    div_state_e       state_q, state_d;
    div_ctx_t         ctx_q;
    logic [CNT_W-1:0] cnt_q;
    logic             accept, step_en, busy;

    logic [XLEN-1:0]  rem_init, quo_init, dsr_init, rem_w, quo_w, result_w;
    logic [CNT_W-1:0] last_idx;
    logic [3:0]       cc_code;

    assign accept  = issue_valid && (state_q == ST_IDLE);
    assign step_en = (state_q == ST_STEP);
    assign busy    = (state_q != ST_IDLE);

    div_prep #(.XLEN(XLEN), .CNT_W(CNT_W)) u_prep (
        .dividend (issue_dividend),
        .divisor  (issue_divisor),
        .word     (issue_word),
        .ext      (issue_ext),
        .rem_init (rem_init),
        .quo_init (quo_init),
        .dsr_init (dsr_init),
        .last_idx (last_idx)
    );

    div_core #(.XLEN(XLEN)) u_core (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .step     (step_en),
        .rem_init (rem_init),
        .quo_init (quo_init),
        .dsr_init (dsr_init),
        .rem_o    (rem_w),
        .quo_o    (quo_w)
    );

    div_post #(.XLEN(XLEN)) u_post (
        .quo      (quo_w),
        .rem      (rem_w),
        .negate   (ctx_q.negate),
        .word     (ctx_q.word),
        .want_rem (ctx_q.want_rem),
        .result   (result_w),
        .cc_code  (cc_code)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (issue_valid)   state_d = ST_STEP;
            ST_STEP: if (cnt_q == '0)   state_d = ST_WRAP;
            ST_WRAP:                    state_d = ST_IDLE;
            default:                    state_d = ST_IDLE;
        endcase
    end

    // Step counter and captured operation context
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            ctx_q <= '0;
        end else if (accept) begin
            cnt_q <= last_idx;
            ctx_q <= '{dest: issue_dest, negate: issue_negate, word: issue_word,
                       want_rem: issue_rem, set_cc: issue_set_cc};
        end else if (step_en && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            done_valid   <= 1'b0;
            done_reg_we  <= 1'b0;
            done_reg_num <= '0;
            done_data    <= '0;
            done_cc_we   <= 1'b0;
            done_cc_mask <= '0;
            done_cc_word <= '0;
        end else if (state_q == ST_WRAP) begin
            done_valid   <= 1'b1;
            done_reg_we  <= 1'b1;
            done_reg_num <= ctx_q.dest;
            done_data    <= result_w;
            done_cc_we   <= ctx_q.set_cc;
            done_cc_mask <= ctx_q.set_cc ? TOP_FIELD : '0;
            done_cc_word <= ctx_q.set_cc ? {cc_code, {(CC_WORD_W-CC_CODE_W){1'b0}}} : '0;
        end else begin
            done_valid   <= 1'b0;
            done_reg_we  <= 1'b0;
            done_cc_we   <= 1'b0;
        end
    end

endmodule

// File: rtl/int_div_unit_chk.sv
`timescale 1ns/1ps
module int_div_unit_chk
    import div_pkg::*;
#(
    parameter int XLEN = 64
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 issue_valid,
    input logic [REG_IDX_W-1:0] issue_dest,
    input logic                 issue_word,
    input logic                 busy,
    input logic                 done_valid,
    input logic [REG_IDX_W-1:0] done_reg_num,
    input logic [XLEN-1:0]      done_data,
    input logic                 done_cc_we,
    input logic [CC_MASK_W-1:0] done_cc_mask,
    input logic [CC_WORD_W-1:0] done_cc_word
);
    localparam int HALF  = XLEN / 2;
    localparam int LIM_W = $clog2(XLEN + 3) + 1;

    logic [REG_IDX_W-1:0] tag_q;
    logic                 word_q;
    logic [LIM_W-1:0]     busy_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q  <= '0;
            word_q <= 1'b0;
        end else if (issue_valid && !busy) begin
            tag_q  <= issue_dest;
            word_q <= issue_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       busy_cnt <= '0;
        else if (busy) busy_cnt <= busy_cnt + 1'b1;
        else           busy_cnt <= '0;
    end

    AST_PULSE_ONE: assert property (@(posedge clk) disable iff (rst)
        done_valid |=> !done_valid); // R2
    AST_QUIET_AFTER_ISSUE: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && !busy) |=> !done_valid); // R2
    AST_BOUNDED_LATENCY: assert property (@(posedge clk) disable iff (rst)
        busy_cnt <= LIM_W'(XLEN + 1)); // R3
    AST_DEST_ECHO: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> (done_reg_num == tag_q)); // R4
    AST_CC_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        done_cc_we |-> done_valid); // R11
    AST_CC_SHAPE: assert property (@(posedge clk) disable iff (rst)
        done_cc_we |-> (done_cc_mask == 8'h80 && done_cc_word[27:0] == '0
                        && $countones(done_cc_word[31:29]) == 1)); // R11
    AST_CC_SIGN_DWORD: assert property (@(posedge clk) disable iff (rst)
        (done_cc_we && !word_q) |-> (done_cc_word[31] == done_data[XLEN-1])); // R12
    AST_CC_SIGN_WORD: assert property (@(posedge clk) disable iff (rst)
        (done_cc_we && word_q) |-> (done_cc_word[31] == done_data[HALF-1])); // R12
    AST_CC_ZERO: assert property (@(posedge clk) disable iff (rst)
        done_cc_we |-> (done_cc_word[29] ==
            (word_q ? (done_data[HALF-1:0] == '0) : (done_data == '0)))); // R12

endmodule

bind int_div_unit int_div_unit_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/test_int_div_unit.sv
`timescale 1ns/1ps
module test_int_div_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue_valid = 1'b0;
    logic [4:0]  issue_dest = '0;
    logic [63:0] issue_dividend = '0, issue_divisor = '0;
    logic        issue_negate = 0, issue_word = 0, issue_ext = 0, issue_rem = 0, issue_set_cc = 0;
    logic        done_valid, done_reg_we, done_cc_we;
    logic [4:0]  done_reg_num;
    logic [63:0] done_data;
    logic [7:0]  done_cc_mask;
    logic [31:0] done_cc_word;

    int checks = 0, errors = 0;
    bit finished = 0;

    logic [63:0] got_data;
    logic [31:0] got_cc;
    logic [7:0]  got_mask;
    logic [4:0]  got_num;
    logic        got_we, got_ccwe;
    int          got_lat;

    always #4 clk = ~clk;

    int_div_unit i_int_div_unit (.*);

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_cc(input logic [63:0] r, input bit word);
        logic neg, zero;
        neg  = word ? r[31] : r[63];
        zero = word ? (r[31:0] == 0) : (r == 0);
        return {neg, !neg && !zero, zero, 1'b0, 28'h0};
    endfunction

    task automatic run_op(input logic [63:0] a, input logic [63:0] b, input bit neg, input bit word,
                          input bit ext, input bit md, input bit cc, input logic [4:0] dest);
        @(negedge clk);
        issue_dividend = a; issue_divisor = b; issue_negate = neg; issue_word = word;
        issue_ext = ext; issue_rem = md; issue_set_cc = cc; issue_dest = dest; issue_valid = 1'b1;
        @(negedge clk);
        issue_valid = 1'b0;
        chk("R2", "valid after issue", {63'b0, done_valid}, 64'd0);
        got_lat = -1;
        for (int n = 1; n <= 80; n++) begin
            @(negedge clk);
            if (done_valid) begin
                got_lat = n; got_data = done_data; got_cc = done_cc_word; got_mask = done_cc_mask;
                got_num = done_reg_num; got_we = done_reg_we; got_ccwe = done_cc_we;
                break;
            end
        end
        @(negedge clk);
        chk("R2", "pulse width", {63'b0, done_valid}, 64'd0);
    endtask

    task automatic t_reset;
        chk("R2", "reset valid", {63'b0, done_valid}, 0);
        chk("R2", "reset reg we", {63'b0, done_reg_we}, 0);
        chk("R2", "reset cc we", {63'b0, done_cc_we}, 0);
    endtask

    task automatic t_basic;
        run_op(64'h10001000, 64'h1111, 0, 0, 0, 0, 0, 5'd17);
        chk("R3", "dword latency", 64'(got_lat), 65);
        chk("R4", "reg we", {63'b0, got_we}, 1);
        chk("R4", "dest echo", {59'b0, got_num}, 17);
        chk("R5", "quotient", got_data, 64'hF001);
        chk("R11", "cc we off", {63'b0, got_ccwe}, 0);
        chk("R11", "mask off", {56'b0, got_mask}, 0);
        chk("R11", "word off", {32'b0, got_cc}, 0);
        run_op(64'h10001000, 64'h1111, 0, 0, 0, 0, 1, 5'd17);
        chk("R5", "quotient again", got_data, 64'hF001);
        chk("R11", "cc we on", {63'b0, got_ccwe}, 1);
        chk("R11", "mask", {56'b0, got_mask}, 64'h80);
        chk("R11", "gt word", {32'b0, got_cc}, 64'h40000000);
        run_op(64'hFEDC_BA98_7654_3210, 64'h0000_0001_2345_6789, 0, 0, 0, 0, 1, 5'd2);
        chk("R5", "wide quotient", got_data, 64'hFEDC_BA98_7654_3210 / 64'h0000_0001_2345_6789);
    endtask

    task automatic t_negate;
        run_op(64'd100, 64'd7, 1, 0, 0, 0, 1, 5'd3);
        chk("R6", "negated quotient", got_data, -64'd14);
        chk("R12", "lt dword", {32'b0, got_cc}, {32'b0, exp_cc(-64'd14, 0)});
    endtask

    task automatic t_rem;
        run_op(64'd100, 64'd7, 0, 0, 0, 1, 1, 5'd4);
        chk("R7", "remainder", got_data, 64'd2);
        run_op(64'd100, 64'd7, 1, 0, 0, 1, 1, 5'd4);
        chk("R7", "signed remainder", got_data, -64'd2);
        run_op(64'd21, 64'd7, 0, 0, 0, 1, 1, 5'd4);
        chk("R7", "zero remainder", got_data, 64'd0);
        chk("R12", "eq code", {32'b0, got_cc}, 64'h20000000);
    endtask

    task automatic t_ext;
        logic [127:0] num, q;
        num = {64'd1, 64'd0};
        q = num / 128'd3;
        run_op(64'd1, 64'd3, 0, 0, 1, 0, 1, 5'd5);
        chk("R8", "ext 1/3", got_data, q[63:0]);
        chk("R3", "ext latency", 64'(got_lat), 65);
        chk("R12", "ext cc", {32'b0, got_cc}, {32'b0, exp_cc(q[63:0], 0)});
        num = {64'h0123_4567_89AB_CDEF, 64'd0};
        q = num / {64'd0, 64'h8000_0000_0000_0001};
        run_op(64'h0123_4567_89AB_CDEF, 64'h8000_0000_0000_0001, 0, 0, 1, 0, 0, 5'd6);
        chk("R8", "ext large", got_data, q[63:0]);
    endtask

    task automatic t_word;
        run_op(64'hFFFF_FFFF_0000_0064, 64'hABCD_0000_0000_0007, 0, 1, 0, 0, 1, 5'd7);
        chk("R9", "word quotient", {32'b0, got_data[31:0]}, 64'd14);
        chk("R3", "word latency", 64'(got_lat), 33);
        run_op(64'h0000_0000_8000_0000, 64'd1, 0, 1, 0, 0, 1, 5'd8);
        chk("R9", "word by one", {32'b0, got_data[31:0]}, 64'h80000000);
        chk("R12", "word sign from bit 31", {32'b0, got_cc}, 64'h80000000);
        run_op(64'd100, 64'd7, 1, 1, 0, 1, 1, 5'd8);
        chk("R9", "word neg rem", {32'b0, got_data[31:0]}, 64'hFFFF_FFFE);
        chk("R12", "word lt", {32'b0, got_cc}, 64'h80000000);
    endtask

    task automatic t_word_ext;
        logic [63:0] q;
        q = {32'd5, 32'd0} / 64'd7;
        run_op({32'd5, 32'hDEAD_BEEF}, 64'hFFFF_0000_0000_0007, 0, 1, 1, 0, 1, 5'd9);
        chk("R10", "word ext quotient", {32'b0, got_data[31:0]}, {32'b0, q[31:0]});
        chk("R3", "word ext latency", 64'(got_lat), 33);
    endtask

    task automatic t_busy_ignore;
        int lat = -1;
        int extra = 0;
        @(negedge clk);
        issue_dividend = 64'd1000; issue_divisor = 64'd10; issue_negate = 0; issue_word = 0;
        issue_ext = 0; issue_rem = 0; issue_set_cc = 0; issue_dest = 5'd11; issue_valid = 1;
        @(negedge clk);
        issue_valid = 0;
        for (int n = 1; n <= 80; n++) begin
            @(negedge clk);
            if (n == 10) begin
                issue_dividend = 64'd77; issue_divisor = 64'd3; issue_dest = 5'd22;
                issue_rem = 1; issue_valid = 1;
            end else begin
                issue_valid = 0;
            end
            if (done_valid) begin
                lat = n; got_data = done_data; got_num = done_reg_num;
                break;
            end
        end
        chk("R1", "latency kept", 64'(lat), 65);
        chk("R1", "first result", got_data, 64'd100);
        chk("R1", "first dest", {59'b0, got_num}, 11);
        for (int n = 0; n < 80; n++) begin
            @(negedge clk);
            if (done_valid) extra++;
        end
        chk("R1", "no second completion", 64'(extra), 0);
    endtask

    task automatic t_div0;
        run_op(64'd1234, 64'd0, 0, 0, 0, 0, 1, 5'd12);
        chk("R13", "completes", 64'(got_lat), 65);
        chk("R13", "bit 28", {63'b0, got_cc[28]}, 0);
        run_op(64'd1234, 64'hFFFF_FFFF_0000_0000, 0, 1, 0, 0, 1, 5'd12);
        chk("R13", "word completes", 64'(got_lat), 33);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_negate();
        t_rem();
        t_ext();
        t_word();
        t_word_ext();
        t_busy_ignore();
        t_div0();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL R3 watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule